// File: doc/BRIEF.md
# Local Bus Timeout Monitor

This block guards a local bus handshake made of a data strobe and a data acknowledge. When the strobe goes active, the block starts a fixed count of clock cycles. If the acknowledge does not arrive before the count runs out, it raises a bus error. This lets an access to an address that nothing decodes finish with an error, so the master does not wait forever. The error stays high until the master drops the strobe. The error is held, not pulsed, so a slow master cannot miss it.

The block has one enable bit, written through a small write port and visible on an output. Clearing the bit stops the monitor. Reset always sets it again. The timeout length is fixed at build time from two parameters: the clock frequency in MHz and the window in microseconds. The default window is 512 µs. Strobe and acknowledge are both active high and may be asynchronous to the clock. Each passes through its own two-stage synchroniser before use.

Top module: `lbt_monitor`

## Requirements
- R1: The limit is LIMIT = CLK_MHZ × TIMEOUT_US clock cycles. It is fixed at build time and nothing at run time can change it.
- R2: Timing starts when the strobe rises. If the strobe is driven high just before rising clock edge 1 and no acknowledge comes, `bus_err` goes high on edge LIMIT+3 and is still low after edge LIMIT+2. The count covers two synchroniser stages, one edge-detect cycle and LIMIT counting cycles.
- R3: Once `bus_err` is high, it stays high until the strobe is released. After the strobe drops, `bus_err` is still high after the 2nd rising edge and low after the 3rd.
- R4: An acknowledge that reaches the pin no later than edge LIMIT+1 (the strobe reached it at edge 1) stops the count, and no error follows. An acknowledge that reaches the pin at edge LIMIT+2 or later does not prevent the error, and it does not clear the error.
- R5: While the enable bit is 0, `bus_err` stays low for any strobe and acknowledge pattern.
- R6: Clearing the enable bit during a count stops that count with no error. Clearing it while `bus_err` is high withdraws the error: `bus_err` is still high after the edge that writes the bit and low after the next edge.
- R7: Reset sets the enable bit to 1 and sets `bus_err` to 0.
- R8: When `cfg_we` is 1 at a rising edge, the enable bit takes the value of `cfg_en_wdata` at that edge. `cfg_en` shows the current value of the bit.
- R9: Each new strobe assertion starts a full new count. Nothing left over from an earlier, shorter access shortens the new window.
- R10: The count starts only on a rising strobe. A strobe that is already high when the monitor is enabled never produces an error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_strb | input | 1 | Local data strobe, active high, asynchronous |
| bus_ack | input | 1 | Local data acknowledge, active high, asynchronous |
| cfg_we | input | 1 | Write strobe for the enable bit |
| cfg_en_wdata | input | 1 | New value for the enable bit |
| cfg_en | output | 1 | Current value of the enable bit |
| bus_err | output | 1 | Bus error, held until the strobe is released |

## Verification
The bench builds the block with CLK_MHZ = 1 and TIMEOUT_US = 16, which gives a 16-cycle limit. With this short limit, every timeout can be reached within a few dozen cycles. The bench checks the exact edge where the error rises. It also checks both sides of the acknowledge boundary (edges LIMIT+1 and LIMIT+2). The reload case and the disable cases also fit within a short run. SYNC_STAGES stays at 2, so the latency counts in R2 to R4 apply as written.

// File: rtl/lbt_pkg.sv
package lbt_pkg;

    // Monitor states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // no access being timed
        ST_COUNT = 2'd1,   // strobe active, waiting for acknowledge
        ST_HOLD  = 2'd2,   // acknowledged, waiting for strobe release
        ST_FAULT = 2'd3    // timed out, error held until strobe release
    } lbt_state_e;

    // Bit positions inside the synchronised input vector
    localparam int unsigned SYNC_STRB = 0;
    localparam int unsigned SYNC_ACK  = 1;
    localparam int unsigned SYNC_W    = 2;

endpackage

// File: rtl/lbt_sync.sv
module lbt_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift chain: stage 0 takes the raw input, each later stage takes the one before it
    always_comb begin
        stage_d[0] = d_in;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[g] <= '0;
                end else begin
                    stage_q[g] <= stage_d[g];
                end
            end
        end
    endgenerate

    assign d_out = stage_q[STAGES-1];

endmodule

// File: rtl/lbt_enreg.sv
module lbt_enreg (
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  logic wdata,
    output logic en
);

    logic en_d;
    logic en_q;

    always_comb begin
        en_d = we ? wdata : en_q;
    end

    // Reset forces the monitor on
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b1;
        end else begin
            en_q <= en_d;
        end
    end

    assign en = en_q;

    // R8: a write takes effect on the next edge
    p_en_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (en_q == $past(wdata)));

    // R8: without a write the bit holds its value
    p_en_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(en_q));

endmodule

// File: rtl/lbt_timer.sv
module lbt_timer
    import lbt_pkg::*;
#(
    parameter int unsigned LIMIT = 16,
    localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic strb_s,
    input  logic ack_s,
    output logic err
);

    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    typedef struct packed {
        lbt_state_e    state;
        logic [CW-1:0] cnt;
        logic          strb_prev;
    } lbt_regs_t;

    lbt_regs_t r_d;
    lbt_regs_t r_q;
    logic      strb_rise;

    always_comb begin
        r_d           = r_q;
        r_d.strb_prev = strb_s;
        strb_rise     = strb_s & ~r_q.strb_prev;

        unique case (r_q.state)
            ST_IDLE: begin
                r_d.cnt = '0;
                if (en && strb_rise) begin
                    r_d.state = ST_COUNT;
                end
            end
            ST_COUNT: begin
                if (!en || !strb_s) begin
                    // disabled or access abandoned: stop quietly
                    r_d.state = ST_IDLE;
                    r_d.cnt   = '0;
                end else if (ack_s) begin
                    // acknowledge wins over a timeout in the same cycle
                    r_d.state = ST_HOLD;
                    r_d.cnt   = '0;
                end else if (r_q.cnt == LAST) begin
                    r_d.state = ST_FAULT;
                    r_d.cnt   = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_HOLD: begin
                if (!strb_s) begin
                    r_d.state = ST_IDLE;
                end
            end
            ST_FAULT: begin
                if (!en || !strb_s) begin
                    r_d.state = ST_IDLE;
                end
            end
            default: begin
                r_d.state = ST_IDLE;
                r_d.cnt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, cnt: '0, strb_prev: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign err = (r_q.state == ST_FAULT);

    // R1: the counter never passes the fixed limit
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= LAST);

    // R2: an error only follows a count that ran out
    p_err_from_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> ($past(r_q.state) == ST_COUNT && $past(r_q.cnt) == LAST));

    // R3: the error ends once the synchronised strobe is low
    p_err_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !strb_s) |=> !err);

    // R3: the error holds while the strobe stays high and the monitor stays enabled
    p_err_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (err && strb_s && en) |=> err);

    // R4: an acknowledge during the count never leads to an error
    p_ack_no_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_COUNT && ack_s) |=> !err);

    // R5: a disabled monitor never has an error in the next cycle
    p_off_no_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !err);

endmodule

// File: rtl/lbt_monitor.sv
module lbt_monitor
    import lbt_pkg::*;
#(
    parameter int unsigned CLK_MHZ     = 200,
    parameter int unsigned TIMEOUT_US  = 512,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_strb,
    input  logic bus_ack,
    input  logic cfg_we,
    input  logic cfg_en_wdata,
    output logic cfg_en,
    output logic bus_err
);

    localparam int unsigned LIMIT = CLK_MHZ * TIMEOUT_US;

    logic [SYNC_W-1:0] raw_in;
    logic [SYNC_W-1:0] sync_out;
    logic              en_bit;

    always_comb begin
        raw_in            = '0;
        raw_in[SYNC_STRB] = bus_strb;
        raw_in[SYNC_ACK]  = bus_ack;
    end

    lbt_sync #(
        .WIDTH  (SYNC_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (raw_in),
        .d_out (sync_out)
    );

    lbt_enreg u_enreg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_en_wdata),
        .en    (en_bit)
    );

    lbt_timer #(
        .LIMIT (LIMIT)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en_bit),
        .strb_s (sync_out[SYNC_STRB]),
        .ack_s  (sync_out[SYNC_ACK]),
        .err    (bus_err)
    );

    assign cfg_en = en_bit;

    // R7: leaving reset, the monitor is enabled and the error is low
    p_reset_state_r7: assert property (@(posedge clk)
        !rst_n |=> (cfg_en && !bus_err));

endmodule

// File: tb/sim_lbt_monitor.sv
`timescale 1ns/1ps
module sim_lbt_monitor;

    localparam int unsigned MHZ = 1;
    localparam int unsigned US  = 16;
    localparam int unsigned LIM = MHZ * US;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_strb = 1'b0;
    logic bus_ack = 1'b0;
    logic cfg_we = 1'b0;
    logic cfg_en_wdata = 1'b0;
    logic cfg_en;
    logic bus_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lbt_monitor #(
        .CLK_MHZ     (MHZ),
        .TIMEOUT_US  (US),
        .SYNC_STAGES (2)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_strb     (bus_strb),
        .bus_ack      (bus_ack),
        .cfg_we       (cfg_we),
        .cfg_en_wdata (cfg_en_wdata),
        .cfg_en       (cfg_en),
        .bus_err      (bus_err)
    );

    // n rising edges, then stop at the following falling edge
    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic write_en(input logic v);
        cfg_we = 1'b1; cfg_en_wdata = v;
        step(1);
        cfg_we = 1'b0;
    endtask

    task automatic idle_bus();
        bus_strb = 1'b0; bus_ack = 1'b0;
        step(6);
    endtask

    task automatic t_reset();
        check("R7 enable after reset", cfg_en, 1'b1);
        check("R7 error after reset", bus_err, 1'b0);
    endtask

    task automatic t_timeout();
        bus_strb = 1'b1;
        step(LIM + 2);
        check("R2 no error at edge LIMIT+2", bus_err, 1'b0);
        step(1);
        check("R2 error at edge LIMIT+3", bus_err, 1'b1);
        step(10);
        check("R3 error held while strobe high", bus_err, 1'b1);
        bus_strb = 1'b0;
        step(2);
        check("R3 error still high 2 edges after release", bus_err, 1'b1);
        step(1);
        check("R3 error low 3 edges after release", bus_err, 1'b0);
        idle_bus();
    endtask

    task automatic t_ack_in_time();
        bus_strb = 1'b1;
        step(LIM);
        bus_ack = 1'b1;
        step(LIM + 6);
        check("R4 ack at edge LIMIT+1 prevents error", bus_err, 1'b0);
        idle_bus();
    endtask

    task automatic t_ack_late();
        bus_strb = 1'b1;
        step(LIM + 1);
        bus_ack = 1'b1;
        step(2);
        check("R4 ack at edge LIMIT+2 too late", bus_err, 1'b1);
        step(5);
        check("R4 late ack does not clear error", bus_err, 1'b1);
        idle_bus();
    endtask

    task automatic t_disabled();
        write_en(1'b0);
        check("R8 enable reads 0 after write", cfg_en, 1'b0);
        bus_strb = 1'b1;
        step(LIM * 2);
        check("R5 no error while disabled", bus_err, 1'b0);
        idle_bus();
        write_en(1'b1);
        check("R8 enable reads 1 after write", cfg_en, 1'b1);
    endtask

    task automatic t_disable_mid();
        bus_strb = 1'b1;
        step(5);
        write_en(1'b0);
        step(LIM + 5);
        check("R6 disable mid-count gives no error", bus_err, 1'b0);
        idle_bus();
        write_en(1'b1);
        bus_strb = 1'b1;
        step(LIM + 3);
        check("R6 error raised before withdraw", bus_err, 1'b1);
        cfg_we = 1'b1; cfg_en_wdata = 1'b0;
        step(1);
        cfg_we = 1'b0;
        check("R6 error still high at write edge", bus_err, 1'b1);
        step(1);
        check("R6 error withdrawn next edge", bus_err, 1'b0);
        idle_bus();
        write_en(1'b1);
    endtask

    task automatic t_reload();
        bus_strb = 1'b1;
        step(LIM - 4);
        bus_strb = 1'b0;
        step(4);
        bus_strb = 1'b1;
        step(LIM + 2);
        check("R9 full window after new strobe", bus_err, 1'b0);
        step(1);
        check("R9 error at edge LIMIT+3 of new strobe", bus_err, 1'b1);
        idle_bus();
    endtask

    task automatic t_held_strobe();
        write_en(1'b0);
        bus_strb = 1'b1;
        step(4);
        write_en(1'b1);
        step(LIM * 2);
        check("R10 strobe high before enable makes no error", bus_err, 1'b0);
        idle_bus();
    endtask

    task automatic t_reset_forces_en();
        write_en(1'b0);
        rst_n = 1'b0;
        step(2);
        check("R7 enable forced by reset", cfg_en, 1'b1);
        rst_n = 1'b1;
        step(2);
        bus_strb = 1'b1;
        step(LIM + 3);
        check("R1 fixed limit after reset", bus_err, 1'b1);
        idle_bus();
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        t_reset();
        t_timeout();
        t_ack_in_time();
        t_ack_late();
        t_disabled();
        t_disable_mid();
        t_reload();
        t_held_strobe();
        t_reset_forces_en();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #250000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule